// File: doc/BRIEF.md
# Two-Bit Counter Branch Direction Predictor

This block guesses, at instruction fetch, whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters. Word-aligned fetch addresses select one counter through a slice of address bits just above the two byte-offset bits. The top bit of the selected counter is driven out combinationally as the taken guess. The guess depends on nothing but the current fetch address.

Once a branch has resolved further down the pipeline, the resolution stage sends back the branch address and the real outcome on a separate update port, qualified by a valid strobe. The addressed counter then moves one step toward that outcome. Each counter has two strong and two weak states, so a counter sitting in a strong state needs two wrong guesses in a row before its guess changes. A synchronous active-low reset places every counter in the weak not-taken state.

Top module: `bht_predictor`

## Requirements
- R1: The table has 2^IDX_W counters. The counter used is the one at fetch_pc[IDX_W+1:2] for lookups and at upd_pc[IDX_W+1:2] for updates. PC bits [1:0] and all bits above IDX_W+1 have no effect on which counter is used.
- R2: pred_taken is a combinational function of fetch_pc alone and equals the most significant bit of the addressed counter.
- R3: While rst_n is low at a rising clock edge, every counter is set to 2'b01 (weak not-taken). After reset, pred_taken is 0 for every fetch address.
- R4: The counter encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. An update with upd_taken=1 raises the counter by one and holds it at 11.
- R5: An update with upd_taken=0 lowers the counter by one and holds it at 00.
- R6: From a strong state, one opposite outcome leaves the guess unchanged. A second consecutive opposite outcome flips it.
- R7: When upd_valid is 0, no counter changes, whatever upd_pc and upd_taken hold.
- R8: If a lookup and an update address the same counter in the same cycle, the lookup returns the value from before the update. The new value becomes visible after that clock edge.
- R9: An update changes only the counter it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | PC_W | Address of the instruction being fetched |
| pred_taken | output | 1 | Taken guess for fetch_pc (1 = taken) |
| upd_valid | input | 1 | A resolved branch is presented on the update port this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch (1 = taken) |

## Verification
The directed cases each target one feature:
- Repeated updates of one kind drive a counter into each saturation end, which tells a clamp apart from a wrapping counter.
- Alternating outcomes after saturation show whether the guess flips after one miss or after two.
- Fetch addresses that differ only in the byte-offset bits or in the bits above the index separate a correct index slice from a shifted one.
- A lookup placed in the same cycle as an update to the same counter tells read-before-write from write-through.

Random traffic confined to a few counters, with random high and low address bits, is then compared against a reference table. This catches crosstalk between entries and updates that leak through while the strobe is low.

// File: rtl/bht_pkg.sv
// Package: shared counter type and the saturating step rule for the
// branch direction predictor. Assumes a 2-bit counter whose top bit is
// the taken guess.
package bht_pkg;

    // Counter states, ordered so that the MSB means "guess taken".
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_t;

    // State every counter takes at reset.
    localparam ctr_t CTR_RESET = CTR_WEAK_NT;

    // Guess carried by a counter state.
    function automatic logic ctr_guess(input ctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/bht_index.sv
// Module: bht_index
// Maps a byte address onto a table index. Assumes word-aligned
// instructions, so the two byte-offset bits are dropped. Bits above the
// index field are ignored, which lets distinct branches alias.
module bht_index #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 12
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    localparam int LSB = 2;
    localparam int MSB = IDX_W + LSB - 1;

    // Slice the index field just above the byte offset.
    assign idx = pc[MSB:LSB];

    generate
        if (PC_W > MSB + 1) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^{pc[PC_W-1:MSB+1], pc[LSB-1:0]};
        end else begin : g_nohi
            logic unused_lo;
            assign unused_lo = ^pc[LSB-1:0];
        end
    endgenerate
endmodule

// File: rtl/bht_sat_ctr.sv
// Module: bht_sat_ctr
// Next-state logic for one 2-bit saturating counter. A taken outcome
// moves up and holds at strong taken; a not-taken outcome moves down and
// holds at strong not-taken. Purely combinational.
module bht_sat_ctr
    import bht_pkg::*;
(
    input  ctr_t cur,
    input  logic taken,
    output ctr_t nxt
);
    // Step one state toward the outcome, clamping at both ends.
    always_comb begin
        nxt = cur;
        unique case (cur)
            CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
            default:       nxt = CTR_RESET;
        endcase
    end
endmodule

// File: rtl/bht_table.sv
// Module: bht_table
// Counter storage with two asynchronous read ports (lookup and update
// read) and one synchronous write port. A write lands on the clock edge,
// so a same-cycle read sees the previous contents. Synchronous
// active-low reset loads every entry with the reset state.
module bht_table
    import bht_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic [IDX_W-1:0] rmw_idx,
    output ctr_t             rmw_ctr,
    input  logic             wr_en,
    input  ctr_t             wr_ctr
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_t mem [DEPTH];

    // Reset all entries, otherwise write the addressed entry when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= CTR_RESET;
            end
        end else if (wr_en) begin
            mem[rmw_idx] <= wr_ctr;
        end
    end

    // Lookup read for the fetch side.
    assign rd_ctr  = mem[rd_idx];
    // Read of the counter about to be updated.
    assign rmw_ctr = mem[rmw_idx];
endmodule

// File: rtl/bht_predictor.sv
// Module: bht_predictor (top)
// Two-bit counter branch direction predictor. Lookups are combinational
// from the fetch address; updates from the resolution stage are a
// read-modify-write committed at the clock edge. Assumes word-aligned
// fetch addresses and at most one update per cycle.
module bht_predictor
    import bht_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    logic [IDX_W-1:0] fetch_idx;
    logic [IDX_W-1:0] upd_idx;
    ctr_t             look_ctr;
    ctr_t             old_ctr;
    ctr_t             new_ctr;

    // Index for the fetch lookup.
    bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_fetch_idx (
        .pc  (fetch_pc),
        .idx (fetch_idx)
    );

    // Index for the resolved branch.
    bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_upd_idx (
        .pc  (upd_pc),
        .idx (upd_idx)
    );

    // Counter step toward the resolved outcome.
    bht_sat_ctr u_step (
        .cur   (old_ctr),
        .taken (upd_taken),
        .nxt   (new_ctr)
    );

    // Counter storage.
    bht_table #(.IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (fetch_idx),
        .rd_ctr  (look_ctr),
        .rmw_idx (upd_idx),
        .rmw_ctr (old_ctr),
        .wr_en   (upd_valid),
        .wr_ctr  (new_ctr)
    );

    // Guess is the top bit of the looked-up counter.
    assign pred_taken = ctr_guess(look_ctr);
endmodule

// File: rtl/bht_checker.sv
// Module: bht_checker
// Port-level properties of bht_predictor, bound to the top module.
// Assumes the bench applies reset before relying on predictions.
module bht_checker #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] fetch_pc,
    input logic            pred_taken,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic            upd_taken
);
    logic seen_rst  = 1'b0;
    logic prev_rstl = 1'b0;
    logic [IDX_W-1:0] f_idx;
    logic [IDX_W-1:0] u_idx;
    logic unused_bits;

    assign f_idx = fetch_pc[IDX_W+1:2];
    assign u_idx = upd_pc[IDX_W+1:2];
    assign unused_bits = ^{fetch_pc, upd_pc};

    // Remember that the table has been reset at least once.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
    end

    // Track whether the previous edge was a reset edge.
    always_ff @(posedge clk) begin
        prev_rstl <= !rst_n;
    end

    AST_RESET_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && prev_rstl) |-> !pred_taken);                              // R3

    AST_TAKEN_KEEPS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && upd_valid && upd_taken && pred_taken && f_idx == u_idx)
        |=> (f_idx != $past(f_idx)) || pred_taken);                            // R4

    AST_NT_KEEPS_NT: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && upd_valid && !upd_taken && !pred_taken && f_idx == u_idx)
        |=> (f_idx != $past(f_idx)) || !pred_taken);                           // R5

    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rst && !upd_valid)
        |=> (f_idx != $past(f_idx)) || $stable(pred_taken));                   // R7
endmodule

bind bht_predictor bht_checker #(.PC_W(PC_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_pc   (fetch_pc),
    .pred_taken (pred_taken),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_taken  (upd_taken)
);

// File: tb/sim_bht_predictor.sv
// Bench for bht_predictor: directed corner cases followed by seeded
// random traffic, checked against a reference counter table.
module sim_bht_predictor;
    localparam int PC_W  = 32;
    localparam int IDX_W = 12;
    localparam int DEPTH = 1 << IDX_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            pred_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    logic [1:0] model [DEPTH];

    always #5 clk = ~clk;

    bht_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    // Index rule from R1.
    function automatic int idx_of(input logic [PC_W-1:0] pc);
        return int'(pc[IDX_W+1:2]);
    endfunction

    // Saturating step from R4 and R5.
    function automatic logic [1:0] step(input logic [1:0] c, input logic t);
        if (t) return (c == 2'b11) ? 2'b11 : c + 2'd1;
        return (c == 2'b00) ? 2'b00 : c - 2'd1;
    endfunction

    // Address with a given index and random other bits.
    function automatic logic [PC_W-1:0] pc_for(input int idx);
        logic [PC_W-1:0] p;
        p = $urandom;
        p[IDX_W+1:2] = idx[IDX_W-1:0];
        return p;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pred_taken=%0b expected %0b (pc=%h)", req, act, exp, fetch_pc);
        end
    endtask

    // One cycle: drive at negedge, check the lookup, apply the update at posedge.
    task automatic cycle(input string req, input logic [PC_W-1:0] fpc,
                         input logic uv, input logic [PC_W-1:0] upc, input logic ut);
        @(negedge clk);
        fetch_pc = fpc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
        #1;
        check(req, pred_taken, model[idx_of(fpc)][1]);
        @(posedge clk);
        if (uv) model[idx_of(upc)] = step(model[idx_of(upc)], ut);
        #1;
        upd_valid = 1'b0;
    endtask

    task automatic train(input int idx, input logic t);
        cycle("R4", pc_for((idx + 1) % DEPTH), 1'b1, pc_for(idx), t);
    endtask

    task automatic probe(input string req, input logic [PC_W-1:0] pc, input logic exp);
        @(negedge clk);
        fetch_pc = pc; upd_valid = 1'b0;
        #1;
        check(req, pred_taken, exp);
        if (model[idx_of(pc)][1] !== exp) begin
            n_fail++;
            $display("FAIL %s: reference table %0b expected %0b", req, model[idx_of(pc)][1], exp);
        end
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < DEPTH; i++) model[i] = 2'b01;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R3: reset state is weak not-taken everywhere.
        for (int i = 0; i < 6; i++) probe("R3", $urandom, 1'b0);

        // R4: one taken flips weak NT to taken; saturate at 11.
        train(5, 1'b1);
        probe("R4", pc_for(5), 1'b1);
        for (int i = 0; i < 3; i++) train(5, 1'b1);
        // R6: one NT from strong taken keeps the guess, second flips it.
        train(5, 1'b0);
        probe("R6", pc_for(5), 1'b1);
        train(5, 1'b0);
        probe("R6", pc_for(5), 1'b0);

        // R5: saturate low, then two taken are needed to flip.
        for (int i = 0; i < 4; i++) train(9, 1'b0);
        train(9, 1'b1);
        probe("R5", pc_for(9), 1'b0);
        train(9, 1'b1);
        probe("R5", pc_for(9), 1'b1);

        // R1: offset bits and bits above the index are ignored.
        for (int i = 0; i < 3; i++) train(20, 1'b1);
        probe("R1", (32'd20 << 2) | 32'd3, 1'b1);
        probe("R1", (32'd20 << 2) | (32'd1 << (IDX_W + 2)) | 32'hF000_0000, 1'b1);
        probe("R1", 32'd21 << 2, 1'b0);

        // R9: neighbour entries are untouched.
        probe("R9", pc_for(19), 1'b0);
        probe("R9", pc_for(DEPTH - 1), 1'b0);

        // R7: strobe low with varied payload changes nothing.
        for (int i = 0; i < 4; i++) cycle("R7", pc_for(20), 1'b0, pc_for(20), 1'b0);
        probe("R7", pc_for(20), 1'b1);

        // R8: same-cycle lookup sees the old value, next cycle the new one.
        train(30, 1'b1);
        cycle("R8", pc_for(30), 1'b1, pc_for(30), 1'b0);
        probe("R8", pc_for(30), 1'b0);

        // R2/R9 random: few indices, random other bits.
        for (int n = 0; n < 3000; n++) begin
            int fi = 40 + int'($urandom_range(0, 5));
            int ui = 40 + int'($urandom_range(0, 5));
            cycle("R2", pc_for(fi), 1'($urandom_range(0, 3) != 0), pc_for(ui),
                  1'($urandom_range(0, 1)));
        end

        // R3: reset in mid-run restores weak not-taken.
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        for (int i = 0; i < DEPTH; i++) model[i] = 2'b01;
        @(negedge clk) rst_n = 1'b1;
        probe("R3", pc_for(5), 1'b0);
        probe("R3", pc_for(20), 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule